// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO

This block buffers data between one write port and one read port, both on a single clock. Behind the ports sit up to four logical FIFO queues. All of them share one storage array. The array is cut into fixed blocks of `BLK_WORDS` words. At reset each queue is given a base block and a block count, and its words wrap inside that region. A queue may be given no blocks at all, or every block.

The write side selects a target queue through a strobed select. It accepts a word on each enabled cycle while that queue has room. The read side also selects its source queue through a strobed select. It shows that queue's oldest word on a registered output without being asked. Each enabled read then moves on to the next word. A word on the output stays counted in its queue until it is read. Changing the read queue therefore never drops data.

Each queue has its own almost-full and almost-empty offsets. At reset all offsets take one of two defaults. A small port can change each offset later. The flags report on the queue selected on the matching port.

Top module: `mq_fifo`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block clears. Both selects go to queue 0, every queue becomes empty, `rd_valid` and `rd_dout` go to zero, and the region map and default offsets are taken from the configuration inputs.
- R2: A write is stored only on an edge where `wr_en` is high and the write-selected queue holds fewer words than its capacity. Attempts made while `wr_full` is high are dropped without effect. `wr_full` is high exactly when the selected queue is at capacity.
- R3: The write select is taken on an edge with `wr_sel_en` high. From the following cycle, `wr_full` and `wr_afull` describe the new queue. A write on that same edge still goes to the previously selected queue.
- R4: When the read-selected queue holds data, its oldest word appears on `rd_dout` with `rd_valid` high, without `rd_en`. A word written into an empty selected queue shows there one cycle after its write edge. An edge with `rd_en` and `rd_valid` both high consumes the shown word and presents the next one.
- R5: When the read select moves to an empty queue, `rd_valid` drops. `rd_dout` keeps the last word shown and holds it for as long as `rd_valid` stays low.
- R6: A word shown but not consumed stays at the head of its queue when the read select moves away. Moving the select to a queue that holds data shows that queue's head on the cycle after the select edge.
- R7: A write and a read may fall on the same edge, to the same queue or to different queues. Each queue keeps strict arrival order.
- R8: Queue g owns `cfg_nblk[g*3 +: 3]` blocks, starting at block `cfg_base[g*2 +: 2]`, so its capacity is that count times `BLK_WORDS`. A queue with zero blocks always reports full and never produces valid data.
- R9: `wr_afull` is high when the write-selected queue's word count plus that queue's almost-full offset is at least its capacity.
- R10: `rd_aempty` is high when the read-selected queue's word count is no greater than that queue's almost-empty offset.
- R11: On reset, every offset is set to 8 if `cfg_dflt_hi` is low, and to 128 if it is high.
- R12: On an edge with `ofs_we` high, the offset of queue `ofs_q` takes `ofs_val`. With `ofs_sel_full` = 1 the almost-full offset is written, and with 0 the almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_base | input | NQ*2 | Base block of each queue, field g at [g*2 +: 2] |
| cfg_nblk | input | NQ*3 | Block count of each queue, field g at [g*3 +: 3] |
| cfg_dflt_hi | input | 1 | Picks default offsets at reset: 0 gives 8, 1 gives 128 |
| wr_sel_en | input | 1 | Load a new write queue select |
| wr_sel | input | 2 | Write queue number |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word |
| wr_full | output | 1 | Write-selected queue is at capacity |
| wr_afull | output | 1 | Write-selected queue is almost full |
| rd_sel_en | input | 1 | Load a new read queue select |
| rd_sel | input | 2 | Read queue number |
| rd_en | input | 1 | Consume the shown word |
| rd_dout | output | 18 | Shown word |
| rd_valid | output | 1 | `rd_dout` holds an unconsumed word of the read-selected queue |
| rd_aempty | output | 1 | Read-selected queue is almost empty |
| ofs_we | input | 1 | Offset write strobe |
| ofs_q | input | 2 | Queue whose offset is written |
| ofs_sel_full | input | 1 | 1 selects the almost-full offset, 0 the almost-empty offset |
| ofs_val | input | 12 | New offset value |

## Verification
The hardest overlap is a consumed read and a read-queue switch on the same edge, often with a write landing in the newly selected queue on that edge too. The output register must then take the new queue's head, and it must ignore the word being written. It must also count the pop against the old queue only. The bench provokes this on purpose, with directed switches while reads are enabled. It also does so at random through frequent select strobes mixed with writes and reads. A word-level reference model checks the result every cycle: shown word, valid, and all flags. Same-queue writes and reads on one edge are driven with the queue both near empty and near full. In these runs the count and the order of words must still match the model.

// File: rtl/mq_pkg.sv
// Package: shared helpers for the multi-queue FIFO.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package mq_pkg;

    // Selects which offset register an offset write targets.
    typedef enum logic {
        OFS_AEMPTY = 1'b0,
        OFS_AFULL  = 1'b1
    } ofs_kind_e;

    // Index width that never collapses to zero bits.
    function automatic int unsigned clog2_min1(input int unsigned v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/mq_qctl.sv
// Module: per-queue region bookkeeping.
// Holds one queue's base block, block count, word count and wrapping
// write/read offsets inside its region, and exports absolute addresses.
// Assumes regions given at reset do not overlap and lie inside the array,
// and that push is never raised when full nor pop when empty.
module mq_qctl #(
    parameter int BLK_WORDS = 512,
    parameter int BIW       = 2,
    parameter int NBW       = 3,
    parameter int AW        = 11,
    parameter int CW        = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [BIW-1:0] cfg_base,
    input  logic [NBW-1:0] cfg_nblk,
    input  logic           push,
    input  logic           pop,
    output logic [CW-1:0]  cnt,
    output logic [CW-1:0]  cap,
    output logic [AW-1:0]  waddr,
    output logic [AW-1:0]  rhead,
    output logic [AW-1:0]  rnext
);

    logic [BIW-1:0] base_r;
    logic [NBW-1:0] nblk_r;
    logic [AW-1:0]  wofs_r;
    logic [AW-1:0]  rofs_r;
    logic [CW-1:0]  cnt_r;
    logic [AW-1:0]  origin;

    // Advance an in-region offset, wrapping at the region size.
    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p,
                                               input logic [CW-1:0] lim);
        return ((CW'(p) + CW'(1)) >= lim) ? '0 : (p + AW'(1));
    endfunction

    assign origin = AW'(base_r) * AW'(BLK_WORDS);
    assign cap    = CW'(nblk_r) * CW'(BLK_WORDS);
    assign cnt    = cnt_r;
    assign waddr  = origin + wofs_r;
    assign rhead  = origin + rofs_r;
    assign rnext  = origin + wrap_inc(rofs_r, cap);

    // Load the region at reset, then track offsets and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r <= cfg_base;
            nblk_r <= cfg_nblk;
            wofs_r <= '0;
            rofs_r <= '0;
            cnt_r  <= '0;
        end else begin
            if (push) wofs_r <= wrap_inc(wofs_r, cap);
            if (pop)  rofs_r <= wrap_inc(rofs_r, cap);
            cnt_r <= cnt_r + CW'(push) - CW'(pop);
        end
    end

endmodule

// File: rtl/mq_store.sv
// Module: shared word array.
// One synchronous write port and one combinational read port; the
// caller registers the read result. No reset on the contents.
module mq_store #(
    parameter int DW    = 18,
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store the incoming word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mq_thresh.sv
// Module: per-queue offset registers and almost flags.
// Offsets load a default at reset and can be rewritten one at a time.
// Flags are formed for the queues currently selected on each port.
module mq_thresh
    import mq_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int QW     = 2,
    parameter int CW     = 12,
    parameter int DEF_LO = 8,
    parameter int DEF_HI = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dflt_hi,
    input  logic          ofs_we,
    input  logic [QW-1:0] ofs_q,
    input  logic          ofs_kind,
    input  logic [CW-1:0] ofs_val,
    input  logic [QW-1:0] wq,
    input  logic [QW-1:0] rq,
    input  logic [CW-1:0] w_cnt,
    input  logic [CW-1:0] w_cap,
    input  logic [CW-1:0] r_cnt,
    output logic          afull,
    output logic          aempty
);

    logic [CW-1:0] af_off [NQ];
    logic [CW-1:0] ae_off [NQ];
    logic [CW-1:0] dflt;

    assign dflt = dflt_hi ? CW'(DEF_HI) : CW'(DEF_LO);

    for (genvar g = 0; g < NQ; g++) begin : g_ofs
        // Hold this queue's two offsets.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                af_off[g] <= dflt;
                ae_off[g] <= dflt;
            end else if (ofs_we && (ofs_q == QW'(g))) begin
                if (ofs_kind == OFS_AFULL) af_off[g] <= ofs_val;
                else                       ae_off[g] <= ofs_val;
            end
        end
    end

    assign afull  = ({1'b0, w_cnt} + {1'b0, af_off[wq]}) >= {1'b0, w_cap};
    assign aempty = r_cnt <= ae_off[rq];

endmodule

// File: rtl/mq_fifo.sv
// Module: multi-queue FIFO top.
// One write and one read port in front of NQ queues sharing a
// block-partitioned array. The read side is first-word-fall-through with
// a non-destructive output register: the shown word leaves its queue only
// when read. Assumes select values below NQ and a static region map.
module mq_fifo
    import mq_pkg::*;
#(
    parameter  int DW        = 18,
    parameter  int NQ        = 4,
    parameter  int NUM_BLK   = 4,
    parameter  int BLK_WORDS = 512,
    parameter  int DEF_LO    = 8,
    parameter  int DEF_HI    = 128,
    localparam int QW        = clog2_min1(NQ),
    localparam int BIW       = clog2_min1(NUM_BLK),
    localparam int NBW       = $clog2(NUM_BLK + 1),
    localparam int DEPTH     = NUM_BLK * BLK_WORDS,
    localparam int AW        = clog2_min1(DEPTH),
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NQ*BIW-1:0] cfg_base,
    input  logic [NQ*NBW-1:0] cfg_nblk,
    input  logic              cfg_dflt_hi,
    input  logic              wr_sel_en,
    input  logic [QW-1:0]     wr_sel,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output logic              wr_full,
    output logic              wr_afull,
    input  logic              rd_sel_en,
    input  logic [QW-1:0]     rd_sel,
    input  logic              rd_en,
    output logic [DW-1:0]     rd_dout,
    output logic              rd_valid,
    output logic              rd_aempty,
    input  logic              ofs_we,
    input  logic [QW-1:0]     ofs_q,
    input  logic              ofs_sel_full,
    input  logic [CW-1:0]     ofs_val
);

    logic [QW-1:0] wq_r;
    logic [QW-1:0] rq_r;
    logic [QW-1:0] rq_nx;
    logic [CW-1:0] q_cnt   [NQ];
    logic [CW-1:0] q_cap   [NQ];
    logic [AW-1:0] q_waddr [NQ];
    logic [AW-1:0] q_rhead [NQ];
    logic [AW-1:0] q_rnext [NQ];
    logic [NQ-1:0] q_push;
    logic [NQ-1:0] q_pop;
    logic          wr_acc;
    logic          rd_pop;
    logic          same_q;
    logic          load_out;
    logic [CW-1:0] nx_left;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] mem_q;
    logic [DW-1:0] dout_r;
    logic          valid_r;

    // Port-side decisions for this cycle.
    assign wr_full  = (q_cnt[wq_r] == q_cap[wq_r]);
    assign wr_acc   = wr_en && !wr_full;
    assign rd_pop   = rd_en && valid_r;
    assign rq_nx    = rd_sel_en ? rd_sel : rq_r;
    assign same_q   = rd_pop && (rq_nx == rq_r);
    assign nx_left  = q_cnt[rq_nx] - CW'(same_q);
    assign load_out = (nx_left != '0);
    assign rd_addr  = same_q ? q_rnext[rq_nx] : q_rhead[rq_nx];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign q_push[g] = wr_acc && (wq_r == QW'(g));
        assign q_pop[g]  = rd_pop && (rq_r == QW'(g));

        mq_qctl #(
            .BLK_WORDS (BLK_WORDS),
            .BIW       (BIW),
            .NBW       (NBW),
            .AW        (AW),
            .CW        (CW)
        ) u_qctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_base (cfg_base[g*BIW +: BIW]),
            .cfg_nblk (cfg_nblk[g*NBW +: NBW]),
            .push     (q_push[g]),
            .pop      (q_pop[g]),
            .cnt      (q_cnt[g]),
            .cap      (q_cap[g]),
            .waddr    (q_waddr[g]),
            .rhead    (q_rhead[g]),
            .rnext    (q_rnext[g])
        );
    end

    mq_store #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_store (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (q_waddr[wq_r]),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (mem_q)
    );

    mq_thresh #(
        .NQ     (NQ),
        .QW     (QW),
        .CW     (CW),
        .DEF_LO (DEF_LO),
        .DEF_HI (DEF_HI)
    ) u_thresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .dflt_hi  (cfg_dflt_hi),
        .ofs_we   (ofs_we),
        .ofs_q    (ofs_q),
        .ofs_kind (ofs_sel_full),
        .ofs_val  (ofs_val),
        .wq       (wq_r),
        .rq       (rq_r),
        .w_cnt    (q_cnt[wq_r]),
        .w_cap    (q_cap[wq_r]),
        .r_cnt    (q_cnt[rq_r]),
        .afull    (wr_afull),
        .aempty   (rd_aempty)
    );

    // Register the write and read queue selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wq_r <= '0;
            rq_r <= '0;
        end else begin
            if (wr_sel_en) wq_r <= wr_sel;
            rq_r <= rq_nx;
        end
    end

    // Output register: show the head of the next read queue, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_r <= 1'b0;
            dout_r  <= '0;
        end else begin
            valid_r <= load_out;
            if (load_out) dout_r <= mem_q;
        end
    end

    assign rd_dout  = dout_r;
    assign rd_valid = valid_r;

endmodule

// File: rtl/mq_fifo_chk.sv
// Module: property checker for mq_fifo, attached by bind.
// Observes per-queue fill levels and the port flags.
module mq_fifo_chk #(
    parameter int NQ = 4,
    parameter int QW = 2,
    parameter int CW = 12,
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] q_cnt [NQ],
    input logic [CW-1:0] q_cap [NQ],
    input logic [QW-1:0] wq,
    input logic [QW-1:0] rq,
    input logic          wr_en,
    input logic          wr_full,
    input logic          wr_afull,
    input logic          rd_en,
    input logic          rd_sel_en,
    input logic          rd_valid,
    input logic          rd_aempty,
    input logic [DW-1:0] rd_dout
);

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        a_r8_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
            q_cnt[g] <= q_cap[g]);

        a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (wq == QW'(g) && wr_full && wr_en) |=> (q_cnt[g] <= $past(q_cnt[g])));
    end

    a_r4_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (q_cnt[rq] != '0));

    a_r4_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en && !rd_sel_en) |=> (rd_valid && $stable(rd_dout)));

    a_r5_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && $past(rst_n)) |-> $stable(rd_dout));

    a_r9_full_implies_afull: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> wr_afull);

    a_r10_empty_is_aempty: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt[rq] == '0) |-> rd_aempty);

endmodule

bind mq_fifo mq_fifo_chk #(
    .NQ (NQ),
    .QW (QW),
    .CW (CW),
    .DW (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_cnt     (q_cnt),
    .q_cap     (q_cap),
    .wq        (wq_r),
    .rq        (rq_r),
    .wr_en     (wr_en),
    .wr_full   (wr_full),
    .wr_afull  (wr_afull),
    .rd_en     (rd_en),
    .rd_sel_en (rd_sel_en),
    .rd_valid  (rd_valid),
    .rd_aempty (rd_aempty),
    .rd_dout   (rd_dout)
);

// File: tb/mq_fifo_bench.sv
// Bench: directed corners plus seeded random traffic, checked every
// cycle against a word-level model of the queues.
module mq_fifo_bench;

    localparam int CLK_T     = 10;
    localparam int DW        = 18;
    localparam int NQ        = 4;
    localparam int NUM_BLK   = 4;
    localparam int BLK_WORDS = 512;
    localparam int QW        = 2;
    localparam int BIW       = 2;
    localparam int NBW       = 3;
    localparam int CW        = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NQ*BIW-1:0] cfg_base = {2'd0, 2'd3, 2'd1, 2'd0};
    logic [NQ*NBW-1:0] cfg_nblk = {3'd0, 3'd1, 3'd2, 3'd1};
    logic              cfg_dflt_hi = 1'b0;
    logic              wr_sel_en, wr_en, rd_sel_en, rd_en, ofs_we, ofs_sel_full;
    logic [QW-1:0]     wr_sel, rd_sel, ofs_q;
    logic [DW-1:0]     wr_data;
    logic [CW-1:0]     ofs_val;
    logic              wr_full, wr_afull, rd_valid, rd_aempty;
    logic [DW-1:0]     rd_dout;

    int                cap_m [NQ] = '{512, 1024, 512, 0};
    logic [DW-1:0]     mq [NQ][$];
    int                m_wq, m_rq, m_afo [NQ], m_aeo [NQ];
    bit                m_valid;
    logic [DW-1:0]     m_dout;
    int                checks = 0, bad = 0, cyc = 0;
    bit                done = 0;

    always #(CLK_T/2) clk = ~clk;

    mq_fifo u_mq_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_nblk(cfg_nblk),
        .cfg_dflt_hi(cfg_dflt_hi), .wr_sel_en(wr_sel_en), .wr_sel(wr_sel),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full), .wr_afull(wr_afull),
        .rd_sel_en(rd_sel_en), .rd_sel(rd_sel), .rd_en(rd_en), .rd_dout(rd_dout),
        .rd_valid(rd_valid), .rd_aempty(rd_aempty), .ofs_we(ofs_we), .ofs_q(ofs_q),
        .ofs_sel_full(ofs_sel_full), .ofs_val(ofs_val)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic bit e_full();
        return mq[m_wq].size() >= cap_m[m_wq];
    endfunction
    function automatic bit e_afull();
        return (mq[m_wq].size() + m_afo[m_wq]) >= cap_m[m_wq];
    endfunction
    function automatic bit e_aempty();
        return mq[m_rq].size() <= m_aeo[m_rq];
    endfunction

    // Apply one clock edge to the model, from the inputs of that edge.
    task automatic model_edge();
        int nq, left;
        bit popx, same, wacc;
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                mq[q].delete();
                m_afo[q] = cfg_dflt_hi ? 128 : 8;
                m_aeo[q] = cfg_dflt_hi ? 128 : 8;
            end
            m_wq = 0; m_rq = 0; m_valid = 0; m_dout = '0;
        end else begin
            nq   = rd_sel_en ? int'(rd_sel) : m_rq;
            popx = rd_en && m_valid;
            same = popx && (nq == m_rq);
            left = mq[nq].size() - (same ? 1 : 0);
            wacc = wr_en && (mq[m_wq].size() < cap_m[m_wq]);
            if (left > 0) m_dout = mq[nq][same ? 1 : 0];
            m_valid = (left > 0);
            if (popx) void'(mq[m_rq].pop_front());
            if (wacc) mq[m_wq].push_back(wr_data);
            if (ofs_we) begin
                if (ofs_sel_full) m_afo[ofs_q] = int'(ofs_val);
                else              m_aeo[ofs_q] = int'(ofs_val);
            end
            if (wr_sel_en) m_wq = int'(wr_sel);
            m_rq = nq;
        end
    endtask

    // One cycle: edge, model update, then compare away from the edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 wr_full", 32'(wr_full), 32'(e_full()));
        chk("R9 wr_afull", 32'(wr_afull), 32'(e_afull()));
        chk("R10 rd_aempty", 32'(rd_aempty), 32'(e_aempty()));
        chk("R4 rd_valid", 32'(rd_valid), 32'(m_valid));
        chk("R5 rd_dout", 32'(rd_dout), 32'(m_dout));
    endtask

    task automatic idle();
        wr_sel_en = 0; wr_en = 0; rd_sel_en = 0; rd_en = 0; ofs_we = 0;
        wr_sel = '0; rd_sel = '0; ofs_q = '0; ofs_sel_full = 0;
        wr_data = '0; ofs_val = '0;
    endtask

    task automatic do_reset(input bit hi);
        idle();
        cfg_dflt_hi = hi;
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        chk("R1 reset valid", 32'(rd_valid), 0);
        chk("R1 reset dout", 32'(rd_dout), 0);
        chk("R1 reset aempty", 32'(rd_aempty), 1);
        chk("R1 reset full", 32'(wr_full), 0);

        // R8: queue 3 has no blocks.
        wr_sel_en = 1; wr_sel = 2'd3; rd_sel_en = 1; rd_sel = 2'd3; tick(); idle();
        chk("R8 zero-block full", 32'(wr_full), 1);
        wr_en = 1; wr_data = 18'h2BEEF; tick(); tick(); idle();
        chk("R8 zero-block never valid", 32'(rd_valid), 0);

        // R3: select queue 0 while writing; that write still targets queue 3.
        wr_sel_en = 1; wr_sel = 2'd0; wr_en = 1; wr_data = 18'h3AAAA; tick(); idle();
        chk("R3 full tracks new queue", 32'(wr_full), 0);

        // R2 / R11: fill queue 0 past capacity with reads parked on queue 2.
        rd_sel_en = 1; rd_sel = 2'd2; tick(); idle();
        for (int i = 0; i < 520; i++) begin
            wr_en = 1; wr_data = 18'(i + 'h1000); tick();
            if (i == 502) chk("R11 low offset afull off", 32'(wr_afull), 0);
            if (i == 503) chk("R11 low offset afull on", 32'(wr_afull), 1);
        end
        idle();
        chk("R2 full at capacity", 32'(wr_full), 1);

        // R4: fall-through on select, then enabled reads.
        rd_sel_en = 1; rd_sel = 2'd0; tick(); idle();
        chk("R4 head valid", 32'(rd_valid), 1);
        chk("R4 head word", 32'(rd_dout), 32'h1000);
        rd_en = 1; repeat (10) tick(); idle();
        chk("R4 after reads", 32'(rd_dout), 32'h100A);

        // R5: switch to empty queue 1, word held; R6: switch back, nothing lost.
        rd_sel_en = 1; rd_sel = 2'd1; tick(); idle();
        chk("R5 valid low", 32'(rd_valid), 0);
        chk("R5 word held", 32'(rd_dout), 32'h100A);
        rd_sel_en = 1; rd_sel = 2'd0; tick(); idle();
        chk("R6 resumed head", 32'(rd_dout), 32'h100A);
        chk("R6 resumed valid", 32'(rd_valid), 1);

        // R7: same-queue then cross-queue concurrent write and read.
        wr_sel_en = 1; wr_sel = 2'd1; rd_sel_en = 1; rd_sel = 2'd1; tick(); idle();
        for (int i = 0; i < 60; i++) begin
            wr_en = 1; rd_en = 1; wr_data = 18'(i + 'h2000); tick();
        end
        idle();
        wr_sel_en = 1; wr_sel = 2'd2; rd_sel_en = 1; rd_sel = 2'd0; tick(); idle();
        for (int i = 0; i < 60; i++) begin
            wr_en = 1; rd_en = 1; wr_data = 18'(i + 'h3000); tick();
        end
        idle();
        chk("R7 cross-queue valid", 32'(rd_valid), 32'(m_valid));

        // R12: program offsets on queue 0.
        wr_sel_en = 1; wr_sel = 2'd0; ofs_we = 1; ofs_q = 2'd0; ofs_sel_full = 1;
        ofs_val = 12'd300; tick(); idle();
        chk("R12 programmed afull", 32'(wr_afull), 32'(e_afull()));
        ofs_we = 1; ofs_q = 2'd0; ofs_sel_full = 0; ofs_val = 12'd500; tick(); idle();
        chk("R12 programmed aempty", 32'(rd_aempty), 1);

        // Random traffic, all requirements compared every cycle.
        for (int i = 0; i < 5000; i++) begin
            wr_sel_en    = ($urandom % 20) == 0;
            wr_sel       = QW'($urandom % NQ);
            wr_en        = ($urandom % 10) < 6;
            wr_data      = DW'($urandom);
            rd_sel_en    = ($urandom % 20) == 0;
            rd_sel       = QW'($urandom % NQ);
            rd_en        = ($urandom % 10) < 5;
            ofs_we       = ($urandom % 50) == 0;
            ofs_q        = QW'($urandom % NQ);
            ofs_sel_full = $urandom % 2;
            ofs_val      = CW'($urandom % 700);
            tick();
        end
        idle();

        // R11: high defaults of 128.
        do_reset(1'b1);
        for (int i = 0; i < 384; i++) begin
            wr_en = 1; wr_data = 18'(i); tick();
            if (i == 127) chk("R11 aempty at 128", 32'(rd_aempty), 1);
            if (i == 128) chk("R11 aempty at 129", 32'(rd_aempty), 0);
            if (i == 382) chk("R11 afull at 383", 32'(wr_afull), 0);
            if (i == 383) chk("R11 afull at 384", 32'(wr_afull), 1);
        end
        idle();
        tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule